// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of one-bit ownership flags that two independent ports share. The two ports sit on either side of a dual-port memory. Software on the two sides uses the flags to agree on which side may touch a shared region of that memory.

A port claims a flag by writing a zero to it. It then reads the flag back to learn whether the claim succeeded. The owner gives the flag up by writing a one.

A claim that loses stays pending. When the owner releases the flag, ownership passes straight to the waiting side. Claims that collide in one clock cycle are resolved in favour of the left port. At no time can both sides own the same flag.

Each side has the following signals:

- a semaphore select;
- a write/read strobe;
- an output enable;
- an array-enable input;
- a flag address, which selects the flag on the lowest address lines;
- one data bit in each direction.

The semaphore path only acts while that side's memory array is not enabled.

Top module: `sem_unit`

## Requirements
- R1: After synchronous reset every flag is free: a read of any flag from either side returns 1, and both data outputs read 1 before any read is issued.
- R2: A write with data 0 to a free flag grants it to the writing side; a read by that side in any later cycle returns 0 (0 means "this side owns the flag").
- R3: A read of a flag that the reading side does not own returns 1, whether the flag is free or owned by the other side.
- R4: When both sides write 0 to the same free flag in the same cycle, the left side becomes the owner and the right side does not.
- R5: A side whose claim was refused keeps it pending; when the owner writes 1 to release the flag, ownership passes to the waiting side in the same update.
- R6: Writing 1 to a flag owned by the other side does not change that flag's owner.
- R7: Writing 0 to a flag the side already owns leaves it owned by that side.
- R8: A select, write or read issued while that side's array-enable input is 1 has no effect on any flag, and it does not update that side's read result.
- R9: While a side's output enable is 0, its data output reads 1; when the output enable returns to 1, the last read result is shown again.
- R10: The flags are independent of each other. Two different flags can be owned by opposite sides at the same time, and an access to one flag leaves every other flag unchanged.
- R11: When the owner releases a flag and no claim is pending from the other side, the flag becomes free.
- R12: The read result is registered: it reflects ownership as it stood at the clock edge where the read was sampled. A read in the cycle after a write therefore sees that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select (1 = access a flag) |
| l_wr | input | 1 | Left strobe: 1 = write, 0 = read |
| l_oe | input | 1 | Left output enable for the data output |
| l_arr_en | input | 1 | Left memory array enable; 1 blocks semaphore access |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 1 | Left write data: 0 = claim, 1 = release |
| l_rdata | output | 1 | Left read result: 0 = owned by left |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right strobe: 1 = write, 0 = read |
| r_oe | input | 1 | Right output enable |
| r_arr_en | input | 1 | Right memory array enable |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 1 | Right write data |
| r_rdata | output | 1 | Right read result: 0 = owned by right |

## Verification
The assertions assume that reset is held for at least one edge before any access. They also assume that the address lies inside the flag bank, which holds by default because 3 bits cover exactly eight flags.

The handoff and priority properties rely on each side issuing at most one access per cycle; the single strobe per side guarantees this.

The random stimulus selects addresses from the full 3-bit range. It mixes claims, releases and reads on both sides with the array enable set now and then, so the blocked-access case is exercised against the same model as the others.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Current owner keeps the flag while its claim stands; otherwise the
    // left claim is considered before the right one.
    function automatic owner_e arbitrate(input owner_e cur,
                                         input logic   l_claim,
                                         input logic   r_claim);
        owner_e nxt;
        if (cur == OWN_LEFT && l_claim)
            nxt = OWN_LEFT;
        else if (cur == OWN_RIGHT && r_claim)
            nxt = OWN_RIGHT;
        else if (l_claim)
            nxt = OWN_LEFT;
        else if (r_claim)
            nxt = OWN_RIGHT;
        else
            nxt = OWN_NONE;
        return nxt;
    endfunction

endpackage

// File: rtl/sem_port.sv
module sem_port #(
    parameter int NUM_FLAGS = 8,
    localparam int AW = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 wr,
    input  logic                 oe,
    input  logic                 arr_en,
    input  logic [AW-1:0]        addr,
    input  logic                 wdata,
    input  logic [NUM_FLAGS-1:0] own,
    output logic [NUM_FLAGS-1:0] claim_set,
    output logic [NUM_FLAGS-1:0] claim_clr,
    output logic                 rdata
);

    logic access, wr_acc, rd_acc;
    logic rd_q;

    assign access = sel & ~arr_en;
    assign wr_acc = access & wr;
    assign rd_acc = access & ~wr;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        logic hit;
        assign hit          = wr_acc && (addr == AW'(i));
        assign claim_set[i] = hit & ~wdata;
        assign claim_clr[i] = hit &  wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= 1'b1;
        else if (rd_acc)
            rd_q <= ~own[addr];
    end

    assign rdata = oe ? rd_q : 1'b1;

    // R12: a sampled read shows the ownership seen at that edge
    a_r12_read_status: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> (rd_q == !$past(own[addr])));

    // R8: a blocked read leaves the held result alone
    a_r8_blocked_read: assert property (@(posedge clk) disable iff (rst)
        (sel && arr_en) |=> $stable(rd_q));

endmodule

// File: rtl/sem_flag.sv
module sem_flag
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_set,
    input  logic l_clr,
    input  logic r_set,
    input  logic r_clr,
    output logic own_l,
    output logic own_r
);

    logic   l_req_q, r_req_q;
    logic   l_req_n, r_req_n;
    owner_e owner_q, owner_n;

    assign l_req_n = l_set | (l_req_q & ~l_clr);
    assign r_req_n = r_set | (r_req_q & ~r_clr);
    assign owner_n = arbitrate(owner_q, l_req_n, r_req_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            l_req_q <= 1'b0;
            r_req_q <= 1'b0;
            owner_q <= OWN_NONE;
        end else begin
            l_req_q <= l_req_n;
            r_req_q <= r_req_n;
            owner_q <= owner_n;
        end
    end

    assign own_l = (owner_q == OWN_LEFT);
    assign own_r = (owner_q == OWN_RIGHT);

    // R4: a tie on a free flag goes to the left side
    a_r4_left_first: assert property (@(posedge clk) disable iff (rst)
        (!own_l && !own_r && l_set && r_set) |=> own_l);

    // R5: release with a waiting right claim hands the flag over
    a_r5_handoff: assert property (@(posedge clk) disable iff (rst)
        (own_l && l_clr && r_req_q && !r_clr) |=> own_r);

    // R6: a release from the non-owner leaves the owner in place
    a_r6_foreign_release: assert property (@(posedge clk) disable iff (rst)
        (own_l && !l_clr && r_clr) |=> own_l);

    // R7: a repeated claim by the owner keeps it owned
    a_r7_reclaim: assert property (@(posedge clk) disable iff (rst)
        (own_r && r_set) |=> own_r);

    // R11: release with nobody waiting frees the flag
    a_r11_free: assert property (@(posedge clk) disable iff (rst)
        (own_r && r_clr && !l_req_q && !l_set) |=> (!own_l && !own_r));

endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
    parameter int NUM_FLAGS = 8,
    localparam int AW = $clog2(NUM_FLAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_sel,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic          l_arr_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_wdata,
    output logic          l_rdata,
    input  logic          r_sel,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic          r_arr_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wdata,
    output logic          r_rdata
);

    logic [NUM_FLAGS-1:0] own_l, own_r;
    logic [NUM_FLAGS-1:0] l_set, l_clr, r_set, r_clr;

    sem_port #(.NUM_FLAGS(NUM_FLAGS)) u_left (
        .clk(clk), .rst(rst), .sel(l_sel), .wr(l_wr), .oe(l_oe),
        .arr_en(l_arr_en), .addr(l_addr), .wdata(l_wdata), .own(own_l),
        .claim_set(l_set), .claim_clr(l_clr), .rdata(l_rdata)
    );

    sem_port #(.NUM_FLAGS(NUM_FLAGS)) u_right (
        .clk(clk), .rst(rst), .sel(r_sel), .wr(r_wr), .oe(r_oe),
        .arr_en(r_arr_en), .addr(r_addr), .wdata(r_wdata), .own(own_r),
        .claim_set(r_set), .claim_clr(r_clr), .rdata(r_rdata)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sem_flag u_flag (
            .clk(clk), .rst(rst),
            .l_set(l_set[i]), .l_clr(l_clr[i]),
            .r_set(r_set[i]), .r_clr(r_clr[i]),
            .own_l(own_l[i]), .own_r(own_r[i])
        );
    end

    // R8: accesses blocked on both sides leave all ownership unchanged
    a_r8_blocked_both: assert property (@(posedge clk) disable iff (rst)
        (l_arr_en && r_arr_en) |=> ($stable(own_l) && $stable(own_r)));

    // R10: with no write on either side no flag changes owner
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (!(l_sel && l_wr) && !(r_sel && r_wr)) |=> ($stable(own_l) && $stable(own_r)));

endmodule

// File: tb/sem_unit_bench.sv
module sem_unit_bench;

    logic clk = 1'b0;
    logic rst;
    logic l_sel, l_wr, l_oe, l_arr_en, l_wdata, l_rdata;
    logic r_sel, r_wr, r_oe, r_arr_en, r_wdata, r_rdata;
    logic [2:0] l_addr, r_addr;

    int checks = 0;
    int errors = 0;

    // model: 0 free, 1 left, 2 right
    int mown[8];
    bit mlreq[8];
    bit mrreq[8];

    always #2 clk = ~clk;

    sem_unit u_sem_unit (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_arr_en(l_arr_en),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_arr_en(r_arr_en),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic int next_owner(int cur, bit lc, bit rc);
        if (cur == 1 && lc) return 1;
        if (cur == 2 && rc) return 2;
        if (lc) return 1;
        if (rc) return 2;
        return 0;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // one access per side; inputs driven just after a falling edge
    task automatic step(input logic ls, input logic lw, input logic la,
                        input logic [2:0] lad, input logic ld,
                        input logic rs, input logic rw, input logic ra,
                        input logic [2:0] rad, input logic rd,
                        input string tag);
        bit lrd, rrd, ew_l, ew_r;
        logic expl, expr;
        lrd  = ls && !lw && !la;
        rrd  = rs && !rw && !ra;
        ew_l = ls && lw && !la;
        ew_r = rs && rw && !ra;
        expl = (mown[lad] == 1) ? 1'b0 : 1'b1;
        expr = (mown[rad] == 2) ? 1'b0 : 1'b1;
        if (ew_l) mlreq[lad] = !ld;
        if (ew_r) mrreq[rad] = !rd;
        for (int i = 0; i < 8; i++)
            mown[i] = next_owner(mown[i], mlreq[i], mrreq[i]);
        l_sel = ls; l_wr = lw; l_arr_en = la; l_addr = lad; l_wdata = ld;
        r_sel = rs; r_wr = rw; r_arr_en = ra; r_addr = rad; r_wdata = rd;
        l_oe = 1'b1; r_oe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        l_sel = 1'b0; r_sel = 1'b0;
        if (lrd) check({tag, " left read"}, l_rdata, expl);
        if (rrd) check({tag, " right read"}, r_rdata, expr);
    endtask

    task automatic idle_left_read(input logic [2:0] a, input string tag);
        step(1, 0, 0, a, 1, 0, 0, 0, 3'd0, 1, tag);
    endtask

    task automatic idle_right_read(input logic [2:0] a, input string tag);
        step(0, 0, 0, 3'd0, 1, 1, 0, 0, a, 1, tag);
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin mown[i] = 0; mlreq[i] = 0; mrreq[i] = 0; end
        rst = 1'b1;
        l_sel = 0; l_wr = 0; l_oe = 1; l_arr_en = 0; l_addr = 0; l_wdata = 1;
        r_sel = 0; r_wr = 0; r_oe = 1; r_arr_en = 0; r_addr = 0; r_wdata = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 left idle", l_rdata, 1'b1);
        check("R1 right idle", r_rdata, 1'b1);
        for (int i = 0; i < 8; i++)
            step(1, 0, 0, 3'(i), 1, 1, 0, 0, 3'(i), 1, "R1");

        // R2 / R12: claim then read in the next cycle
        step(1, 1, 0, 3'd3, 0, 0, 0, 0, 3'd0, 1, "R2 claim");
        idle_left_read(3'd3, "R12 R2");
        // R3: other side sees 1
        idle_right_read(3'd3, "R3");
        // R10: opposite owners on different flags
        step(0, 0, 0, 3'd0, 1, 1, 1, 0, 3'd5, 0, "R10 claim");
        step(1, 0, 0, 3'd5, 1, 1, 0, 0, 3'd5, 1, "R10 flag5");
        step(1, 0, 0, 3'd3, 1, 1, 0, 0, 3'd3, 1, "R10 flag3");
        // R7: reclaim by owner
        step(1, 1, 0, 3'd3, 0, 0, 0, 0, 3'd0, 1, "R7 reclaim");
        idle_left_read(3'd3, "R7");
        // R6: foreign release
        step(0, 0, 0, 3'd0, 1, 1, 1, 0, 3'd3, 1, "R6 release");
        step(1, 0, 0, 3'd3, 1, 1, 0, 0, 3'd3, 1, "R6");
        // R4: tie on flag 1
        step(1, 1, 0, 3'd1, 0, 1, 1, 0, 3'd1, 0, "R4 tie");
        step(1, 0, 0, 3'd1, 1, 1, 0, 0, 3'd1, 1, "R4");
        // R5: left releases, right waiting
        step(1, 1, 0, 3'd1, 1, 0, 0, 0, 3'd0, 1, "R5 release");
        step(1, 0, 0, 3'd1, 1, 1, 0, 0, 3'd1, 1, "R5");
        // R11: release with nobody waiting
        step(0, 0, 0, 3'd0, 1, 1, 1, 0, 3'd1, 1, "R11 release");
        step(1, 0, 0, 3'd1, 1, 1, 0, 0, 3'd1, 1, "R11");
        // R8: blocked claim and blocked read
        step(1, 1, 1, 3'd6, 0, 0, 0, 0, 3'd0, 1, "R8 blocked");
        idle_left_read(3'd6, "R8 flag6");
        idle_left_read(3'd3, "R8 prep");
        step(1, 0, 1, 3'd6, 1, 0, 0, 0, 3'd0, 1, "R8 blocked read");
        check("R8 held result", l_rdata, 1'b0);
        // R9: output enable gating (left still shows 0 for flag 3)
        l_oe = 1'b0; #1;
        check("R9 oe low", l_rdata, 1'b1);
        l_oe = 1'b1; #1;
        check("R9 oe high", l_rdata, 1'b0);

        // random mix; R4 R5 R6 R7 R10 R11 exercised against the model
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7) == 0,
                 3'($urandom_range(0, 7)), $urandom_range(0, 1),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7) == 0,
                 3'($urandom_range(0, 7)), $urandom_range(0, 1),
                 "R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule